// File: doc/BRIEF.md
# Burst Half-Line Fill Buffer

This block sits in a bus interface between the external bus and two caches, one for instructions and one for data. Both caches use 16-byte lines, but a cacheable fetch miss brings back a 32-byte burst. The block puts the two 8-byte beats of the first 16-byte half together and delivers them to the requesting cache as one line. It parks the two beats of the second half in a holding buffer that belongs to that cache. A later miss from the same cache that falls on the parked half is then served from the buffer in one cycle, with no bus cycle.

Each cache has its own holding buffer, and the two never disturb each other. A held half is consumed by the lookup that hits it, dropped when a new burst starts for the same cache, and dropped by an invalidate whose address falls inside it. An invalidate is seen by both buffers. When a lookup and an invalidate target the same line in the same cycle, the invalidate wins.

Top module: `fhb_fill_buffer`

## Requirements
- R1: After synchronous reset, `line_valid` and `lk_hit` are 0 and both holding buffers are empty, so any lookup misses.
- R2: A burst is four beats tagged by `beat_phase` 0, 1, 2, 3 in that order, with `beat_addr` carrying the 32-byte-aligned base. One cycle after the phase-1 beat is accepted, `line_valid` is high for exactly one cycle. At that point `line_data` holds the phase-1 beat in its upper 64 bits and the phase-0 beat in its lower 64 bits. `line_addr` is the base with bits 4:0 cleared, and `line_chan` is the burst's channel (0 = instruction, 1 = data).
- R3: After the phase-3 beat is accepted, a lookup on that channel to any byte address in [base+16, base+31] gives `lk_hit`=1 in the next cycle. `lk_data` then holds the phase-3 beat in bits 127:64 and the phase-2 beat in bits 63:0.
- R4: A lookup that hits consumes the held half, so a repeat lookup to the same line misses.
- R5: A lookup misses when its line tag differs from the held one (this includes the first-half address of the burst) or when it names the other channel. A burst on one channel leaves the other channel's held half untouched.
- R6: A new burst on a channel replaces that channel's held half. The earlier line then misses and the new line hits with the new beats.
- R7: An invalidate whose address falls in a held line empties that buffer. An invalidate to any other line leaves it valid.
- R8: A lookup and an invalidate to the same line in the same cycle resolve as a miss, and the line is gone afterwards.
- R9: From the phase-0 beat of a new burst until its phase-3 beat, a lookup on that channel misses, including a lookup to the line held before that burst.
- R10: An invalidate that matches the second-half line of a burst in the same cycle as its phase-3 beat leaves that buffer empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beat_valid | input | 1 | A bus beat is present |
| beat_chan | input | CH_W | Channel of the burst (0 instruction, 1 data) |
| beat_phase | input | 2 | Beat position within the burst, 0..3 |
| beat_addr | input | ADDR_W | Burst base address, 32-byte aligned |
| beat_data | input | BEAT_W | Beat payload |
| line_valid | output | 1 | First-half line ready for the cache |
| line_chan | output | CH_W | Channel of the delivered line |
| line_addr | output | ADDR_W | Address of the delivered line |
| line_data | output | 2*BEAT_W | Delivered line, later beat in the upper half |
| lk_valid | input | 1 | Lookup request from a later miss |
| lk_chan | input | CH_W | Channel of the lookup |
| lk_addr | input | ADDR_W | Byte address of the lookup |
| lk_hit | output | 1 | Lookup found the held half (one cycle later) |
| lk_data | output | 2*BEAT_W | Held line, valid when lk_hit |
| inv_valid | input | 1 | Invalidate request, seen by both channels |
| inv_addr | input | ADDR_W | Byte address to invalidate |

## Verification
Two functions can land in the same cycle. A lookup can consume a held line while an invalidate removes that same line, and an invalidate can strike the line that a phase-3 beat is just filling. The bench raises both requests at the same falling edge, so the design sees them together at one rising edge. It counts the result as correct only if `lk_hit` stays low in that cycle and a lookup made afterwards still misses. It also places a lookup between the phase-0 and phase-3 beats of a new burst, so the request and the burst overlap in time.

// File: rtl/fhb_pkg.sv
package fhb_pkg;

  // Position of a beat within a 32-byte burst; the order is significant:
  // the first two beats build the delivered line, the last two are held.
  typedef enum logic [1:0] {
    BP_LO0 = 2'd0,
    BP_LO1 = 2'd1,
    BP_HI0 = 2'd2,
    BP_HI1 = 2'd3
  } fhb_phase_e;

  function automatic logic is_held_phase(fhb_phase_e ph);
    return (ph == BP_HI0) || (ph == BP_HI1);
  endfunction

endpackage

// File: rtl/fhb_front_half.sv
module fhb_front_half
  import fhb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BEAT_W    = 64,
  parameter int CH_W      = 1,
  parameter int BURST_OFS = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        beat_valid,
  input  fhb_phase_e                  beat_phase,
  input  logic [CH_W-1:0]             beat_chan,
  input  logic [ADDR_W-1:BURST_OFS]   beat_base,
  input  logic [BEAT_W-1:0]           beat_data,
  output logic                        line_valid,
  output logic [CH_W-1:0]             line_chan,
  output logic [ADDR_W-1:0]           line_addr,
  output logic [2*BEAT_W-1:0]         line_data
);

  logic [BEAT_W-1:0] first_beat_q;
  logic              take_first;
  logic              take_second;

  assign take_first  = beat_valid && (beat_phase == BP_LO0);
  assign take_second = beat_valid && (beat_phase == BP_LO1);

  always_ff @(posedge clk) begin
    if (rst) begin
      first_beat_q <= '0;
      line_valid   <= 1'b0;
      line_chan    <= '0;
      line_addr    <= '0;
      line_data    <= '0;
    end else begin
      line_valid <= take_second;
      if (take_first) begin
        first_beat_q <= beat_data;
      end
      if (take_second) begin
        line_data <= {beat_data, first_beat_q};
        line_chan <= beat_chan;
        line_addr <= {beat_base, {BURST_OFS{1'b0}}};
      end
    end
  end

endmodule

// File: rtl/fhb_hold_store.sv
module fhb_hold_store #(
  parameter int BEAT_W = 64,
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic                wr_upper,
  input  logic [CH_W-1:0]     wr_chan,
  input  logic [BEAT_W-1:0]   wr_data,
  input  logic                rd_en,
  input  logic [CH_W-1:0]     rd_chan,
  output logic [2*BEAT_W-1:0] rd_data
);

  // Two narrow arrays, one per beat slot, so each write touches one beat
  // and a read returns a full line from a registered port.
  logic [BEAT_W-1:0] lower_mem [NUM_CH];
  logic [BEAT_W-1:0] upper_mem [NUM_CH];

  always_ff @(posedge clk) begin
    if (wr_en && !wr_upper) begin
      lower_mem[wr_chan] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_upper) begin
      upper_mem[wr_chan] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_data <= {upper_mem[rd_chan], lower_mem[rd_chan]};
    end
  end

endmodule

// File: rtl/fhb_tag_ctl.sv
module fhb_tag_ctl
  import fhb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_CH    = 2,
  parameter int CH_W      = 1,
  parameter int LINE_OFS  = 4,
  parameter int BURST_OFS = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        beat_valid,
  input  fhb_phase_e                  beat_phase,
  input  logic [CH_W-1:0]             beat_chan,
  input  logic [ADDR_W-1:BURST_OFS]   beat_base,
  input  logic                        lk_valid,
  input  logic [CH_W-1:0]             lk_chan,
  input  logic [ADDR_W-1:LINE_OFS]    lk_tag,
  input  logic                        inv_valid,
  input  logic [ADDR_W-1:LINE_OFS]    inv_tag,
  output logic                        lk_hit
);

  localparam int TAG_W = ADDR_W - LINE_OFS;

  logic [NUM_CH-1:0] hit_vec;
  logic [TAG_W-1:0]  fill_tag;
  logic              lk_inv_clash;
  logic              fill_inv_clash;

  // The held half is always the upper 16 bytes of the burst.
  assign fill_tag       = {beat_base, 1'b1};
  assign lk_inv_clash   = inv_valid && (inv_tag == lk_tag);
  assign fill_inv_clash = inv_valid && (inv_tag == fill_tag);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic             valid_q;
    logic [TAG_W-1:0] tag_q;
    logic             mine;
    logic             burst_start;
    logic             burst_done;
    logic             lk_match;
    logic             inv_match;

    assign mine        = beat_valid && (beat_chan == CH_W'(c));
    assign burst_start = mine && (beat_phase == BP_LO0);
    assign burst_done  = mine && (beat_phase == BP_HI1);
    assign lk_match    = lk_valid && (lk_chan == CH_W'(c)) && valid_q && (tag_q == lk_tag);
    assign inv_match   = inv_valid && valid_q && (tag_q == inv_tag);
    assign hit_vec[c]  = lk_match && !lk_inv_clash;

    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q <= 1'b0;
        tag_q   <= '0;
      end else if (burst_done) begin
        valid_q <= !fill_inv_clash;
        tag_q   <= fill_tag;
      end else if (burst_start || lk_match || inv_match) begin
        valid_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit <= 1'b0;
    end else begin
      lk_hit <= |hit_vec;
    end
  end

endmodule

// File: rtl/fhb_fill_buffer.sv
module fhb_fill_buffer
  import fhb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BEAT_W = 64,
  parameter int NUM_CH = 2,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int LINE_W = 2 * BEAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat_valid,
  input  logic [CH_W-1:0]   beat_chan,
  input  logic [1:0]        beat_phase,
  input  logic [ADDR_W-1:0] beat_addr,
  input  logic [BEAT_W-1:0] beat_data,
  output logic              line_valid,
  output logic [CH_W-1:0]   line_chan,
  output logic [ADDR_W-1:0] line_addr,
  output logic [LINE_W-1:0] line_data,
  input  logic              lk_valid,
  input  logic [CH_W-1:0]   lk_chan,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [LINE_W-1:0] lk_data,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr
);

  localparam int BEAT_BYTES = BEAT_W / 8;
  localparam int LINE_OFS   = $clog2(2 * BEAT_BYTES);
  localparam int BURST_OFS  = LINE_OFS + 1;

  fhb_phase_e                  phase;
  logic [ADDR_W-1:BURST_OFS]   beat_base;
  logic [ADDR_W-1:LINE_OFS]    lk_tag;
  logic [ADDR_W-1:LINE_OFS]    inv_tag;
  logic                        unused_low_bits;

  assign phase     = fhb_phase_e'(beat_phase);
  assign beat_base = beat_addr[ADDR_W-1:BURST_OFS];
  assign lk_tag    = lk_addr[ADDR_W-1:LINE_OFS];
  assign inv_tag   = inv_addr[ADDR_W-1:LINE_OFS];
  assign unused_low_bits = ^{beat_addr[BURST_OFS-1:0], lk_addr[LINE_OFS-1:0],
                             inv_addr[LINE_OFS-1:0]};

  fhb_front_half #(
    .ADDR_W   (ADDR_W),
    .BEAT_W   (BEAT_W),
    .CH_W     (CH_W),
    .BURST_OFS(BURST_OFS)
  ) front_i (
    .clk       (clk),
    .rst       (rst),
    .beat_valid(beat_valid),
    .beat_phase(phase),
    .beat_chan (beat_chan),
    .beat_base (beat_base),
    .beat_data (beat_data),
    .line_valid(line_valid),
    .line_chan (line_chan),
    .line_addr (line_addr),
    .line_data (line_data)
  );

  fhb_hold_store #(
    .BEAT_W(BEAT_W),
    .NUM_CH(NUM_CH),
    .CH_W  (CH_W)
  ) store_i (
    .clk     (clk),
    .wr_en   (beat_valid && is_held_phase(phase)),
    .wr_upper(phase == BP_HI1),
    .wr_chan (beat_chan),
    .wr_data (beat_data),
    .rd_en   (lk_valid),
    .rd_chan (lk_chan),
    .rd_data (lk_data)
  );

  fhb_tag_ctl #(
    .ADDR_W   (ADDR_W),
    .NUM_CH   (NUM_CH),
    .CH_W     (CH_W),
    .LINE_OFS (LINE_OFS),
    .BURST_OFS(BURST_OFS)
  ) tags_i (
    .clk       (clk),
    .rst       (rst),
    .beat_valid(beat_valid),
    .beat_phase(phase),
    .beat_chan (beat_chan),
    .beat_base (beat_base),
    .lk_valid  (lk_valid),
    .lk_chan   (lk_chan),
    .lk_tag    (lk_tag),
    .inv_valid (inv_valid),
    .inv_tag   (inv_tag),
    .lk_hit    (lk_hit)
  );

endmodule

// File: rtl/fhb_fill_buffer_chk.sv
module fhb_fill_buffer_chk #(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              beat_valid,
  input logic [1:0]        beat_phase,
  input logic              line_valid,
  input logic [ADDR_W-1:0] line_addr,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              lk_hit,
  input logic              inv_valid,
  input logic [ADDR_W-1:0] inv_addr
);

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!line_valid && !lk_hit)); // R1

  AST_LINE_FOLLOWS_BEAT1: assert property (@(posedge clk) disable iff (rst)
    line_valid |-> $past(beat_valid && (beat_phase == 2'd1))); // R2

  AST_LINE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    line_valid |=> !line_valid); // R2

  AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    line_valid |-> (line_addr[LINE_OFS:0] == '0)); // R2

  AST_HIT_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> $past(lk_valid)); // R3

  AST_CLASH_MISSES: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && inv_valid && (lk_addr[ADDR_W-1:LINE_OFS] == inv_addr[ADDR_W-1:LINE_OFS]))
      |=> !lk_hit); // R8

endmodule

bind fhb_fill_buffer fhb_fill_buffer_chk #(
  .ADDR_W  (ADDR_W),
  .LINE_OFS(LINE_OFS)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .beat_valid(beat_valid),
  .beat_phase(beat_phase),
  .line_valid(line_valid),
  .line_addr (line_addr),
  .lk_valid  (lk_valid),
  .lk_addr   (lk_addr),
  .lk_hit    (lk_hit),
  .inv_valid (inv_valid),
  .inv_addr  (inv_addr)
);

// File: tb/fhb_fill_buffer_tb_top.sv
module fhb_fill_buffer_tb_top;

  localparam int ADDR_W = 32;
  localparam int BEAT_W = 64;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              beat_valid = 1'b0;
  logic [0:0]        beat_chan = '0;
  logic [1:0]        beat_phase = '0;
  logic [ADDR_W-1:0] beat_addr = '0;
  logic [BEAT_W-1:0] beat_data = '0;
  logic              line_valid;
  logic [0:0]        line_chan;
  logic [ADDR_W-1:0] line_addr;
  logic [127:0]      line_data;
  logic              lk_valid = 1'b0;
  logic [0:0]        lk_chan = '0;
  logic [ADDR_W-1:0] lk_addr = '0;
  logic              lk_hit;
  logic [127:0]      lk_data;
  logic              inv_valid = 1'b0;
  logic [ADDR_W-1:0] inv_addr = '0;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  fhb_fill_buffer #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .NUM_CH(2)) dut_i (
    .clk(clk), .rst(rst),
    .beat_valid(beat_valid), .beat_chan(beat_chan), .beat_phase(beat_phase),
    .beat_addr(beat_addr), .beat_data(beat_data),
    .line_valid(line_valid), .line_chan(line_chan), .line_addr(line_addr),
    .line_data(line_data),
    .lk_valid(lk_valid), .lk_chan(lk_chan), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_data(lk_data),
    .inv_valid(inv_valid), .inv_addr(inv_addr)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input logic [ADDR_W-1:0] base, input int k);
    return {base, 32'hC0DE_0000 + 32'(k)};
  endfunction

  task automatic drive_beat(input logic ch, input logic [1:0] ph,
                            input logic [ADDR_W-1:0] base);
    beat_valid = 1'b1;
    beat_chan  = ch;
    beat_phase = ph;
    beat_addr  = base;
    beat_data  = pat(base, ph);
  endtask

  // Full burst; first-half line is checked the cycle after phase 1.
  task automatic send_burst(input logic ch, input logic [ADDR_W-1:0] base);
    @(negedge clk); drive_beat(ch, 2'd0, base);
    @(negedge clk); drive_beat(ch, 2'd1, base);
    @(negedge clk);
    check(line_valid == 1'b1, "R2 line_valid", 128'(line_valid), 128'd1);
    check(line_data == {pat(base, 1), pat(base, 0)}, "R2 line_data", line_data,
          {pat(base, 1), pat(base, 0)});
    check(line_addr == base && line_chan == ch, "R2 line_addr/chan",
          {line_chan, line_addr}, {ch, base});
    drive_beat(ch, 2'd2, base);
    @(negedge clk);
    check(line_valid == 1'b0, "R2 single pulse", 128'(line_valid), 128'd0);
    drive_beat(ch, 2'd3, base);
    @(negedge clk);
    beat_valid = 1'b0;
  endtask

  task automatic lookup(input logic ch, input logic [ADDR_W-1:0] a, input bit exp_hit,
                        input logic [ADDR_W-1:0] base, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_chan = ch; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    check(lk_hit == exp_hit, req, 128'(lk_hit), 128'(exp_hit));
    if (exp_hit)
      check(lk_data == {pat(base, 3), pat(base, 2)}, req, lk_data,
            {pat(base, 3), pat(base, 2)});
  endtask

  task automatic invalidate(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    inv_valid = 1'b1; inv_addr = a;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  task automatic t_reset;
    check(line_valid == 1'b0 && lk_hit == 1'b0, "R1 outputs idle",
          {line_valid, lk_hit}, 128'd0);
    lookup(1'b0, 32'h0000_0010, 1'b0, '0, "R1 empty ch0");
    lookup(1'b1, 32'h0000_0010, 1'b0, '0, "R1 empty ch1");
  endtask

  task automatic t_basic;
    send_burst(1'b0, 32'h0000_1000);
    lookup(1'b0, 32'h0000_101C, 1'b1, 32'h0000_1000, "R3 held half hit");
    lookup(1'b0, 32'h0000_1010, 1'b0, '0, "R4 consumed");
  endtask

  task automatic t_channels;
    send_burst(1'b1, 32'h0000_2000);
    send_burst(1'b0, 32'h0000_3000);
    lookup(1'b0, 32'h0000_2010, 1'b0, '0, "R5 wrong channel");
    lookup(1'b1, 32'h0000_2000, 1'b0, '0, "R5 first-half tag");
    lookup(1'b1, 32'h0000_2014, 1'b1, 32'h0000_2000, "R5 other channel kept");
    lookup(1'b0, 32'h0000_3010, 1'b1, 32'h0000_3000, "R5 ch0 hit");
  endtask

  task automatic t_overwrite;
    send_burst(1'b0, 32'h0000_4000);
    send_burst(1'b0, 32'h0000_5000);
    lookup(1'b0, 32'h0000_4010, 1'b0, '0, "R6 old line gone");
    lookup(1'b0, 32'h0000_5010, 1'b1, 32'h0000_5000, "R6 new line");
  endtask

  task automatic t_invalidate;
    send_burst(1'b1, 32'h0000_6000);
    invalidate(32'h0000_7010);
    lookup(1'b1, 32'h0000_6018, 1'b1, 32'h0000_6000, "R7 unrelated invalidate");
    send_burst(1'b1, 32'h0000_6000);
    invalidate(32'h0000_601F);
    lookup(1'b1, 32'h0000_6010, 1'b0, '0, "R7 matching invalidate");
  endtask

  task automatic t_clash;
    send_burst(1'b0, 32'h0000_8000);
    @(negedge clk);
    lk_valid = 1'b1; lk_chan = 1'b0; lk_addr = 32'h0000_8010;
    inv_valid = 1'b1; inv_addr = 32'h0000_8014;
    @(negedge clk);
    lk_valid = 1'b0; inv_valid = 1'b0;
    check(lk_hit == 1'b0, "R8 same-cycle miss", 128'(lk_hit), 128'd0);
    lookup(1'b0, 32'h0000_8010, 1'b0, '0, "R8 line gone");
  endtask

  task automatic t_in_flight;
    send_burst(1'b0, 32'h0000_9000);
    @(negedge clk); drive_beat(1'b0, 2'd0, 32'h0000_A000);
    @(negedge clk); drive_beat(1'b0, 2'd1, 32'h0000_A000);
    lk_valid = 1'b1; lk_chan = 1'b0; lk_addr = 32'h0000_9010;
    @(negedge clk);
    lk_valid = 1'b0;
    check(lk_hit == 1'b0, "R9 old line during burst", 128'(lk_hit), 128'd0);
    drive_beat(1'b0, 2'd2, 32'h0000_A000);
    lk_valid = 1'b1; lk_addr = 32'h0000_A010;
    @(negedge clk);
    lk_valid = 1'b0;
    check(lk_hit == 1'b0, "R9 new line before fill", 128'(lk_hit), 128'd0);
    drive_beat(1'b0, 2'd3, 32'h0000_A000);
    @(negedge clk);
    beat_valid = 1'b0;
    lookup(1'b0, 32'h0000_A010, 1'b1, 32'h0000_A000, "R9 new line after fill");
  endtask

  task automatic t_fill_inv;
    @(negedge clk); drive_beat(1'b1, 2'd0, 32'h0000_B000);
    @(negedge clk); drive_beat(1'b1, 2'd1, 32'h0000_B000);
    @(negedge clk); drive_beat(1'b1, 2'd2, 32'h0000_B000);
    @(negedge clk); drive_beat(1'b1, 2'd3, 32'h0000_B000);
    inv_valid = 1'b1; inv_addr = 32'h0000_B010;
    @(negedge clk);
    beat_valid = 1'b0; inv_valid = 1'b0;
    lookup(1'b1, 32'h0000_B010, 1'b0, '0, "R10 invalidate during fill");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_channels();
    t_overwrite();
    t_invalidate();
    t_clash();
    t_in_flight();
    t_fill_inv();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule